// File: doc/BRIEF.md
# Chainable Serial DAC Input Register

This block is the digital front end of one channel of a serially loaded digital-to-analog converter, built so that many of them can be strung into one long shift path. A host frames a transfer by pulling a frame-select line low and then sends bits on a data line. The block takes each bit on a falling edge of the serial clock, most significant bit first, into a 16-bit input register. When chaining is switched on, the oldest bit of that register is driven onto a serial output pin. The data line of the next channel is wired to that pin. Each extra channel in the path therefore adds sixteen serial clocks to a transfer.

The input register does not drive the converter directly. A separate, active-low load strobe copies bits 11:0 of the input register into a 12-bit output code register on its falling edge. The strobe acts whether or not a frame is open. Several channels that share one strobe therefore all change their codes in the same cycle. The converter's analog stage is not part of this block. The latched code is brought out for checking.

All serial pins are sampled by a free-running system clock, then passed through synchronizers and edge detectors. The block therefore sits in one clock domain.

Top module: `sdac_chain_reg`

## Requirements
- R1: A falling edge on `sclk` while `sync_n` is low shifts the input register left by one bit, and `sdin` enters bit 0. A word is sent most significant bit first.
- R2: A falling edge on `sclk` while `sync_n` is high leaves the input register unchanged. The state of the input register can be seen through `sdout` and through a later load.
- R3: With `chain_en` high, `sdout` equals bit 15 of the input register. It changes only after a capture edge. A word shifted in is therefore presented on `sdout` during the next sixteen captures, starting with its first (most significant) bit.
- R4: With `chain_en` low, `sdout` is held at 0 during all shifting.
- R5: A falling edge on `ldac_n` copies bits 11:0 of the input register into `dac_code`. At no other time does `dac_code` change, including while a new word is being shifted in.
- R6: Bits 15:12 of the word have no effect on `dac_code`.
- R7: An active-low `rst_n` clears the input register and sets `dac_code` and `sdout` to 0 at once, without waiting for a clock edge.
- R8: A falling edge on `ldac_n` is honoured while `sync_n` is low. The load then takes the partly shifted register contents as they stand.
- R9: When more than 16 bits are clocked in during one frame, only the last 16 are kept. The resulting code is bits 11:0 of the last word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk | input | 1 | Serial clock; a bit is captured on its falling edge |
| sync_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data in, most significant bit first |
| ldac_n | input | 1 | Active-low load strobe; its falling edge latches the code |
| chain_en | input | 1 | Static strap; high enables the serial output |
| sdout | output | 1 | Serial output to the next channel's `sdin` |
| dac_code | output | 12 | Latched converter code |

## Verification
The assertions take for granted that `sclk`, `sync_n`, `sdin` and `ldac_n` are slow compared with `clk`. Each level must be held for at least the synchronizer depth plus two clock cycles, so that every pin edge becomes exactly one detected pulse. They also take for granted that `sdin` is settled before the `sclk` fall that captures it. Finally, they take for granted that `chain_en` is a strap, and they check `sdout` only in cycles where it has not just changed. The stimulus holds every serial phase for four system clocks. It changes `sdin` only on a rising `sclk`. It changes `chain_en` only between transfers, with the serial lines idle.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  // Lane positions of the sampled serial pins inside the synchronizer bank.
  localparam int unsigned LANES   = 4;
  localparam int unsigned LN_SCLK = 0;
  localparam int unsigned LN_SYNC = 1;
  localparam int unsigned LN_SDIN = 2;
  localparam int unsigned LN_LDAC = 3;

  // Idle level of each lane, loaded at reset so that no false edge appears:
  // clock high, frame closed, data low, load strobe high.
  localparam logic [LANES-1:0] LANE_IDLE = 4'b1011;

endpackage

// File: rtl/sdac_in_sync.sv
// Bank of multi-stage synchronizers with a falling-edge detector per lane.
module sdac_in_sync #(
  parameter int unsigned             LANES  = 4,
  parameter int unsigned             STAGES = 2,
  parameter logic [LANES-1:0]        IDLE   = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] raw_i,
  output logic [LANES-1:0] lvl_o,
  output logic [LANES-1:0] fell_o
);

  localparam int unsigned TOP = STAGES - 1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;
    logic              prev_q;
    logic              prev_d;

    // next-state
    always_comb begin
      pipe_d = {pipe_q[TOP-1:0], raw_i[g]};
      prev_d = pipe_q[TOP];
    end

    // registers
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q <= {STAGES{IDLE[g]}};
        prev_q <= IDLE[g];
      end else begin
        pipe_q <= pipe_d;
        prev_q <= prev_d;
      end
    end

    assign lvl_o[g]  = pipe_q[TOP];
    assign fell_o[g] = prev_q & ~pipe_q[TOP];

    // A pin edge yields a single detected pulse (capture and load, R1/R5).
    p_edge_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fell_o[g] |=> !fell_o[g]);
  end

endmodule

// File: rtl/sdac_shift_stage.sv
// Input register: one 16-bit stage of a serial shift chain.
module sdac_shift_stage #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);

  localparam int unsigned MSB = WORD_W - 1;

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;

  // next-state: shift left, new bit enters at the bottom
  always_comb begin
    word_d = word_q;
    if (shift_en) begin
      word_d = {word_q[MSB-1:0], bit_i};
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_d;
    end
  end

  assign word_o = word_q;

  // Bits move up one place and the sampled data bit lands in bit 0.
  p_shift_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word_q[0] == $past(bit_i)) &&
                 (word_q[MSB:1] == $past(word_q[MSB-1:0])));

  // Without a qualified capture the register keeps its contents.
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word_q));

endmodule

// File: rtl/sdac_out_latch.sv
// Output code register, loaded from the low bits of the input register.
module sdac_out_latch #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] word_i,
  output logic [CODE_W-1:0] code_o
);

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_d;

  // next-state: upper word bits are dropped
  always_comb begin
    code_d = code_q;
    if (load_en) begin
      code_d = word_i[CODE_W-1:0];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else begin
      code_q <= code_d;
    end
  end

  assign code_o = code_q;

  p_code_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> code_q == $past(word_i[CODE_W-1:0]));

  p_code_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(code_q));

endmodule

// File: rtl/sdac_chain_reg.sv
// Top: chainable serial DAC input/output register pair.
module sdac_chain_reg
  import sdac_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned CODE_W      = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              sdin,
  input  logic              ldac_n,
  input  logic              chain_en,
  output logic              sdout,
  output logic [CODE_W-1:0] dac_code
);

  localparam int unsigned MSB = WORD_W - 1;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_i = rst_pipe_q[RST_STAGES-1];

  // Sampling of the serial pins.
  logic [LANES-1:0] pin_raw;
  logic [LANES-1:0] pin_lvl;
  logic [LANES-1:0] pin_fell;

  always_comb begin
    pin_raw          = '0;
    pin_raw[LN_SCLK] = sclk;
    pin_raw[LN_SYNC] = sync_n;
    pin_raw[LN_SDIN] = sdin;
    pin_raw[LN_LDAC] = ldac_n;
  end

  sdac_in_sync #(
    .LANES  (LANES),
    .STAGES (SYNC_STAGES),
    .IDLE   (LANE_IDLE)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .raw_i  (pin_raw),
    .lvl_o  (pin_lvl),
    .fell_o (pin_fell)
  );

  // Clock enables derived from the detected edges.
  logic shift_en;
  logic load_en;

  assign shift_en = pin_fell[LN_SCLK] & ~pin_lvl[LN_SYNC];
  assign load_en  = pin_fell[LN_LDAC];

  logic [WORD_W-1:0] word;

  sdac_shift_stage #(
    .WORD_W (WORD_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .shift_en (shift_en),
    .bit_i    (pin_lvl[LN_SDIN]),
    .word_o   (word)
  );

  sdac_out_latch #(
    .WORD_W (WORD_W),
    .CODE_W (CODE_W)
  ) u_latch (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .load_en (load_en),
    .word_i  (word),
    .code_o  (dac_code)
  );

  // Oldest bit of the input register feeds the next channel when enabled.
  assign sdout = chain_en & word[MSB];

  // The serial output moves only after a capture edge.
  p_sdout_steady_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (chain_en && $past(chain_en) && !$past(shift_en)) |-> $stable(sdout));

endmodule

// File: tb/sdac_chain_reg_tb_top.sv
module sdac_chain_reg_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PHASE      = 4;   // system clocks per serial phase

  typedef struct packed {
    logic [15:0] w_a;
    logic [15:0] w_b;
    logic        two;
    logic        chain;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    {16'hA5C3, 16'h0000, 1'b0, 1'b0},
    {16'h0FFF, 16'h0000, 1'b0, 1'b1},
    {16'hF123, 16'h0000, 1'b0, 1'b0},
    {16'h0123, 16'h0000, 1'b0, 1'b1},
    {16'h8001, 16'h7E5A, 1'b1, 1'b1},
    {16'hBEEF, 16'h1234, 1'b1, 1'b0},
    {16'hC3A5, 16'hFFFF, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sclk, sync_n, sdin, ldac_n, chain_en;
  logic        sdout;
  logic [11:0] dac_code;

  int n_tests = 0;
  int n_fail  = 0;
  logic done = 1'b0;
  logic [11:0] exp_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdac_chain_reg dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .sync_n   (sync_n),
    .sdin     (sdin),
    .ldac_n   (ldac_n),
    .chain_en (chain_en),
    .sdout    (sdout),
    .dac_code (dac_code)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One serial bit; optionally checks sdout just before the capture edge.
  task automatic shift_bit(input logic b, input logic chk, input logic expo, input string req);
    sdin = b;
    wait_clk(PHASE);
    if (chk) check(req, {15'd0, sdout}, {15'd0, expo});
    sclk = 1'b0;
    wait_clk(PHASE);
    sclk = 1'b1;
  endtask

  task automatic send_word(input logic [15:0] w, input logic chk,
                           input logic [15:0] expw, input string req);
    for (int i = 15; i >= 0; i--) shift_bit(w[i], chk, expw[i], req);
  endtask

  task automatic frame_open();
    sync_n = 1'b0;
    wait_clk(PHASE);
  endtask

  task automatic frame_close();
    wait_clk(PHASE);
    sync_n = 1'b1;
    wait_clk(PHASE);
  endtask

  task automatic pulse_ldac();
    ldac_n = 1'b0;
    wait_clk(PHASE);
    ldac_n = 1'b1;
    wait_clk(PHASE);
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b1; sync_n = 1'b1; sdin = 1'b0; ldac_n = 1'b1;
    chain_en = 1'b1;
    exp_code = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R7: state after reset
    check("R7", {4'd0, dac_code}, 16'h0000);
    check("R7", {15'd0, sdout}, 16'h0000);

    // Vector table: R1 R3 R4 R5 R6 R9
    for (int v = 0; v < NV; v++) begin
      logic [15:0] last;
      logic [15:0] expw;
      chain_en = VECS[v].chain;
      wait_clk(PHASE);
      last = VECS[v].two ? VECS[v].w_b : VECS[v].w_a;
      expw = VECS[v].chain ? VECS[v].w_a : 16'h0000;
      frame_open();
      if (VECS[v].two) begin
        send_word(VECS[v].w_a, 1'b0, 16'h0, "R1");
        send_word(last, 1'b1, expw, VECS[v].chain ? "R3" : "R4");
      end else begin
        send_word(last, 1'b0, 16'h0, "R1");
      end
      frame_close();
      check("R5", {4'd0, dac_code}, {4'd0, exp_code});  // unchanged before load
      pulse_ldac();
      exp_code = last[11:0];
      check(VECS[v].two ? "R9" : "R1", {4'd0, dac_code}, {4'd0, exp_code});
    end

    // R6: only upper bits differ from the loaded word
    chain_en = 1'b1;
    frame_open(); send_word(16'h5ABC, 1'b0, 16'h0, "R6"); frame_close();
    pulse_ldac();
    check("R6", {4'd0, dac_code}, 16'h0ABC);
    frame_open(); send_word(16'hAABC, 1'b0, 16'h0, "R6"); frame_close();
    pulse_ldac();
    check("R6", {4'd0, dac_code}, 16'h0ABC);

    // R2: clock edges outside a frame are ignored
    frame_open(); send_word(16'h1357, 1'b0, 16'h0, "R2"); frame_close();
    pulse_ldac();
    check("R5", {4'd0, dac_code}, 16'h0357);
    for (int i = 0; i < 16; i++) shift_bit(1'b1, 1'b1, 1'b0, "R2");
    pulse_ldac();
    check("R2", {4'd0, dac_code}, 16'h0357);

    // R8: load strobe inside an open frame takes the partial contents
    begin
      logic [23:0] part;
      part = {16'h1357, 8'hC6};
      frame_open();
      for (int i = 7; i >= 0; i--) shift_bit(part[i], 1'b0, 1'b0, "R8");
      pulse_ldac();
      check("R8", {4'd0, dac_code}, {4'd0, part[11:0]});
      frame_close();
    end

    // R3 then R7: raise the oldest bit, then reset mid-run
    frame_open(); send_word(16'h8ABC, 1'b0, 16'h0, "R3"); frame_close();
    check("R3", {15'd0, sdout}, 16'h0001);
    pulse_ldac();
    check("R5", {4'd0, dac_code}, 16'h0ABC);
    @(negedge clk);
    rst_n = 1'b0;
    #(CLK_PERIOD/5);
    check("R7", {4'd0, dac_code}, 16'h0000);
    check("R7", {15'd0, sdout}, 16'h0000);
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(5);
    pulse_ldac();
    check("R7", {4'd0, dac_code}, 16'h0000);

    // R4: serial output quiet with chaining off, even with a high oldest bit
    chain_en = 1'b0;
    wait_clk(PHASE);
    frame_open(); send_word(16'hFFFF, 1'b0, 16'h0, "R4");
    send_word(16'hFFFF, 1'b1, 16'h0000, "R4");
    frame_close();
    check("R4", {15'd0, sdout}, 16'h0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule